// File: doc/BRIEF.md
# Dual-Rate Serial Word Receiver

This block receives one channel of a self-clocking, return-to-zero serial word stream. The line arrives as a pair of digital levels. The pair reads HI, LO or NULL, and each bit is a HI or LO pulse followed by a NULL spacer. Every clock cycle is one sample. The bit rate is the clock divided by 10, or by 80 when the slow rate is selected. The block counts consecutive samples to recover each bit. It treats a long NULL stretch as the end of a word, assembles a 32-bit or 25-bit word and computes a parity status for it.

An optional two-bit source/destination match can reject words. An accepted word is latched and a ready flag is raised. A host reads the word as two 16-bit halves, picked by a select input and gated by an enable input. Reading the second half clears the flag.

For self-test, a loopback pair, normally the serial output of a companion transmitter, can replace the line pair. A build option inverts the loopback pair, so that a second instance receives the complement of the word.

Top module: `serial_word_rx`

## Requirements
- R1: With `slowRate`=0 a bit lasts 10 samples; with `slowRate`=1 it lasts 80 samples. A word ends when the line has been NULL for more than two bit times (more than 20 or more than 160 consecutive samples).
- R2: `shortWord`=0 expects 32 bits per word and `shortWord`=1 expects 25. A word with any other bit count is discarded.
- R3: The line decodes as HI for A=1,B=0, as LO for A=0,B=1, and as NULL otherwise. One bit (HI=1, LO=0) is captured once a non-NULL level has held for 3 consecutive samples. A pulse of 2 samples or fewer is ignored.
- R4: The parity status is 1 when the received bits hold an even number of ones and 0 when they hold an odd number. It is shown in bit 8 of the first half.
- R5: With `sdEnable`=1, a word is accepted only if word bit 9 equals `sdMatchX` and word bit 10 equals `sdMatchY`. With `sdEnable`=0 the match inputs are ignored.
- R6: Word bit k is the k-th bit received. First half (`hostSel`=0): [7:0]=bits 8..1, [8]=parity status, [10:9]=bits 31,30, [12:11]=bits 10,9, [13]=bit 11, [15:14]=bits 13,12. Second half (`hostSel`=1): [15:0]=bits 29..14 in 32-bit mode. In 25-bit mode it holds bits 24..14 in [10:0], and [15:11] read 0. Bits that were not received read as 0.
- R7: `hostData` is 0 whenever `hostEn`=0.
- R8: `wordReady` rises in the clock after an accepted word ends. It clears at a clock edge where `hostEn`=1 and `hostSel`=1. Reading the first half does not clear it.
- R9: An accepted word that completes before a read replaces the stored word, and `wordReady` stays 1.
- R10: A word that ends with too few or too many bits leaves the stored word and `wordReady` unchanged.
- R11: With `loopEn`=1, the `loopA`/`loopB` pair replaces `lineA`/`lineB`. With `INVERT_LOOP`=1 the loopback pair is swapped, so the instance receives the complemented word.
- R12: `rstN`=0 clears `wordReady`, the stored halves, the bit counter and the sampling counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (10x or 80x the bit rate) |
| rstN | input | 1 | Active-low reset |
| lineA | input | 1 | Line level A |
| lineB | input | 1 | Line level B |
| loopEn | input | 1 | Selects the loopback pair instead of the line |
| loopA | input | 1 | Loopback level A |
| loopB | input | 1 | Loopback level B |
| slowRate | input | 1 | 0: clock/10 bit rate, 1: clock/80 bit rate |
| shortWord | input | 1 | 0: 32-bit words, 1: 25-bit words |
| sdEnable | input | 1 | Enables the source/destination match |
| sdMatchX | input | 1 | Value required in word bit 9 |
| sdMatchY | input | 1 | Value required in word bit 10 |
| hostSel | input | 1 | 0: first half, 1: second half |
| hostEn | input | 1 | Drives the selected half onto hostData |
| hostData | output | 16 | Host read data |
| wordReady | output | 1 | An accepted word is waiting to be read |

## Verification
The embedded properties check the following on every cycle:
- a bit-capture strobe never fires twice in a row, and the word-end strobe fires once per gap;
- `wordReady` rises only after a word end;
- a second-half read always clears the flag;
- the stored first half changes only at a word end;
- every freshly accepted word under an active filter carries the programmed match bits.

Only the bench's scenarios can show the rest. These are the sample-accurate bit recovery at both rates, the rejection of short glitches, the half-word field layout and parity value, the discard of partial and overlong words, and the complemented loopback in the inverting build.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    LVL_NULL = 2'd0,
    LVL_LO   = 2'd1,
    LVL_HI   = 2'd2
  } lineLvl_t;

  typedef struct packed {
    logic captureBit;
    logic bitValue;
    logic wordEnd;
  } rxStrobe_t;
endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
#(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_DIV    = 80,
  parameter int CNT_W       = 8,
  parameter bit INVERT_LOOP = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineA,
  input  logic      lineB,
  input  logic      loopEn,
  input  logic      loopA,
  input  logic      loopB,
  input  logic      slowRate,
  output rxStrobe_t strobes
);
  localparam int CAPTURE_RUN = 3;
  localparam logic [CNT_W-1:0] FAST_GAP = CNT_W'(2 * FAST_DIV);
  localparam logic [CNT_W-1:0] SLOW_GAP = CNT_W'(2 * SLOW_DIV);
  localparam logic [CNT_W-1:0] NULL_MAX = '1;

  logic testA, testB, srcA, srcB;
  lineLvl_t rawLvl, lvlQ, prevLvl;
  logic [1:0] runCnt;
  logic [CNT_W-1:0] nullCnt;
  logic [CNT_W-1:0] gapLimit;

  generate
    if (INVERT_LOOP) begin : gLoopInv
      assign testA = loopB;
      assign testB = loopA;
    end else begin : gLoopDir
      assign testA = loopA;
      assign testB = loopB;
    end
  endgenerate

  assign srcA = loopEn ? testA : lineA;
  assign srcB = loopEn ? testB : lineB;

  always_comb begin
    if (srcA && !srcB)      rawLvl = LVL_HI;
    else if (!srcA && srcB) rawLvl = LVL_LO;
    else                    rawLvl = LVL_NULL;
  end

  assign gapLimit = slowRate ? SLOW_GAP : FAST_GAP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ    <= LVL_NULL;
      prevLvl <= LVL_NULL;
      runCnt  <= '0;
      nullCnt <= '0;
    end else begin
      lvlQ    <= rawLvl;
      prevLvl <= lvlQ;
      if (lvlQ == LVL_NULL) begin
        runCnt <= '0;
        if (nullCnt != NULL_MAX) nullCnt <= nullCnt + 1'b1;
      end else begin
        nullCnt <= '0;
        if (lvlQ == prevLvl) begin
          if (runCnt != 2'd3) runCnt <= runCnt + 1'b1;
        end else begin
          runCnt <= 2'd1;
        end
      end
    end
  end

  always_comb begin
    strobes.captureBit = (lvlQ != LVL_NULL) && (lvlQ == prevLvl) &&
                         (runCnt == 2'(CAPTURE_RUN - 1));
    strobes.bitValue   = (lvlQ == LVL_HI);
    strobes.wordEnd    = (lvlQ == LVL_NULL) && (nullCnt == gapLimit);
  end

  // R3: one capture per level run
  assert_single_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureBit |=> !strobes.captureBit);
  // R1: a gap is reported once
  assert_single_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wordEnd |=> !strobes.wordEnd);
endmodule

// File: rtl/swr_datapath.sv
module swr_datapath
  import swr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 25,
  parameter int HALF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobes,
  input  logic              shortWord,
  input  logic              sdEnable,
  input  logic              sdMatchX,
  input  logic              sdMatchY,
  input  logic              hostSel,
  input  logic              hostEn,
  output logic [HALF_W-1:0] hostData,
  output logic              wordReady
);
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int BITCNT_W = IDX_W + 1;
  localparam logic [BITCNT_W-1:0] CNT_MAX = '1;

  logic [BITCNT_W-1:0] bitCount, expLen;
  logic [WORD_W-1:0]   shiftWord;
  logic [HALF_W-1:0]   half1Q, half2Q, half1Next, half2Next;
  logic                readyQ, parStat, lenOk, sdOk, accept, readClr;

  assign expLen  = shortWord ? BITCNT_W'(SHORT_W) : BITCNT_W'(WORD_W);
  assign lenOk   = (bitCount == expLen);
  assign parStat = ~^shiftWord;
  assign sdOk    = !sdEnable || ((shiftWord[8] == sdMatchX) && (shiftWord[9] == sdMatchY));
  assign accept  = strobes.wordEnd && lenOk && sdOk;
  assign readClr = hostEn && hostSel;

  always_comb begin
    half1Next        = '0;
    half1Next[7:0]   = shiftWord[7:0];
    half1Next[8]     = parStat;
    half1Next[10:9]  = {shiftWord[30], shiftWord[29]};
    half1Next[12:11] = {shiftWord[9], shiftWord[8]};
    half1Next[13]    = shiftWord[10];
    half1Next[15:14] = {shiftWord[12], shiftWord[11]};
    if (shortWord) half2Next = {5'b0, shiftWord[23:13]};
    else           half2Next = shiftWord[28:13];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount  <= '0;
      shiftWord <= '0;
    end else if (strobes.wordEnd) begin
      bitCount  <= '0;
      shiftWord <= '0;
    end else if (strobes.captureBit) begin
      if (bitCount < BITCNT_W'(WORD_W))
        shiftWord[bitCount[IDX_W-1:0]] <= strobes.bitValue;
      if (bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      half1Q <= '0;
      half2Q <= '0;
      readyQ <= 1'b0;
    end else if (accept) begin
      half1Q <= half1Next;
      half2Q <= half2Next;
      readyQ <= 1'b1;
    end else if (readClr) begin
      readyQ <= 1'b0;
    end
  end

  assign hostData  = hostEn ? (hostSel ? half2Q : half1Q) : '0;
  assign wordReady = readyQ;

  // R8: the flag rises only after a word end
  assert_ready_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyQ) |-> $past(strobes.wordEnd));
  // R8: a second-half read clears the flag
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && hostSel && !strobes.wordEnd) |=> !readyQ);
  // R9: the stored word changes only at a word end
  assert_hold_between_words_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.wordEnd) |-> $stable(half1Q));
  // R5: a word accepted under the filter carries the programmed bits
  assert_filter_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(readyQ) && $past(sdEnable)) |-> (half1Q[12:11] == {$past(sdMatchY), $past(sdMatchX)}));
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import swr_pkg::*;
#(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_DIV    = 80,
  parameter int CNT_W       = 8,
  parameter int WORD_W      = 32,
  parameter int SHORT_W     = 25,
  parameter int HALF_W      = 16,
  parameter bit INVERT_LOOP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineA,
  input  logic              lineB,
  input  logic              loopEn,
  input  logic              loopA,
  input  logic              loopB,
  input  logic              slowRate,
  input  logic              shortWord,
  input  logic              sdEnable,
  input  logic              sdMatchX,
  input  logic              sdMatchY,
  input  logic              hostSel,
  input  logic              hostEn,
  output logic [HALF_W-1:0] hostData,
  output logic              wordReady
);
  rxStrobe_t strobes;

  swr_ctrl #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .CNT_W(CNT_W), .INVERT_LOOP(INVERT_LOOP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB),
    .loopEn(loopEn), .loopA(loopA), .loopB(loopB),
    .slowRate(slowRate), .strobes(strobes)
  );

  swr_datapath #(
    .WORD_W(WORD_W), .SHORT_W(SHORT_W), .HALF_W(HALF_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shortWord(shortWord),
    .sdEnable(sdEnable), .sdMatchX(sdMatchX), .sdMatchY(sdMatchY),
    .hostSel(hostSel), .hostEn(hostEn), .hostData(hostData), .wordReady(wordReady)
  );
endmodule

// File: tb/serial_word_rx_test.sv
`timescale 1ns/1ps
module serial_word_rx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineA = 0, lineB = 0, loopEn = 0, loopA = 0, loopB = 0;
  logic slowRate = 0, shortWord = 0, sdEnable = 0, sdMatchX = 0, sdMatchY = 0;
  logic hostSel = 0, hostEn = 0;
  logic [15:0] hostData, hostDataInv;
  logic wordReady, readyInv;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serial_word_rx uut (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB), .loopEn(loopEn),
    .loopA(loopA), .loopB(loopB), .slowRate(slowRate), .shortWord(shortWord),
    .sdEnable(sdEnable), .sdMatchX(sdMatchX), .sdMatchY(sdMatchY),
    .hostSel(hostSel), .hostEn(hostEn), .hostData(hostData), .wordReady(wordReady));

  serial_word_rx #(.INVERT_LOOP(1'b1)) uutInv (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB), .loopEn(loopEn),
    .loopA(loopA), .loopB(loopB), .slowRate(slowRate), .shortWord(shortWord),
    .sdEnable(sdEnable), .sdMatchX(sdMatchX), .sdMatchY(sdMatchY),
    .hostSel(hostSel), .hostEn(hostEn), .hostData(hostDataInv), .wordReady(readyInv));

  function automatic logic [31:0] maskBits(input logic [31:0] w, input int n);
    return (n >= 32) ? w : (w & ((32'h1 << n) - 1));
  endfunction

  function automatic logic [15:0] expHalf1(input logic [31:0] w, input int n);
    logic [31:0] m = maskBits(w, n);
    logic [15:0] h;
    h[7:0] = m[7:0];
    h[8] = ~^m;
    h[10:9] = {m[30], m[29]};
    h[12:11] = {m[9], m[8]};
    h[13] = m[10];
    h[15:14] = {m[12], m[11]};
    return h;
  endfunction

  function automatic logic [15:0] expHalf2(input logic [31:0] w, input int n);
    logic [31:0] m = maskBits(w, n);
    return (n == 25) ? {5'b0, m[23:13]} : m[28:13];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input bit viaLoop);
    @(negedge clk);
    if (viaLoop) begin loopA = a; loopB = b; end
    else begin lineA = a; lineB = b; end
  endtask

  task automatic sendWord(input logic [31:0] w, input int n, input int ratio,
                          input bit viaLoop, input int glitchAfter);
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s < ratio / 2; s++) drive(w[k], !w[k], viaLoop);
      for (int s = 0; s < ratio / 2; s++) drive(1'b0, 1'b0, viaLoop);
      if (k == glitchAfter) begin
        for (int s = 0; s < 2; s++) drive(1'b1, 1'b0, viaLoop);
        for (int s = 0; s < 3; s++) drive(1'b0, 1'b0, viaLoop);
      end
    end
    for (int s = 0; s < 3 * ratio; s++) drive(1'b0, 1'b0, viaLoop);
  endtask

  task automatic readHalf(input logic sel, output logic [15:0] d, output logic [15:0] dInv);
    @(negedge clk);
    hostEn = 1'b1;
    hostSel = sel;
    #1;
    d = hostData;
    dInv = hostDataInv;
    @(negedge clk);
    hostEn = 1'b0;
    hostSel = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] d, di;
    logic [31:0] w;
    int n;
    void'($urandom(32'h1234_5a5a));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 reset ready", wordReady, 0);
    hostEn = 1'b1; #1;
    chk("R12 reset data", hostData, 16'h0);
    @(negedge clk); hostEn = 1'b0;

    // Random words, both lengths, fast rate
    for (int i = 0; i < 6; i++) begin
      w = $urandom();
      n = (i % 3 == 2) ? 25 : 32;
      shortWord = (n == 25);
      sendWord(w, n, 10, 1'b0, -1);
      chk("R8 ready after word", wordReady, 1);
      readHalf(1'b0, d, di);
      chk("R6/R4 first half", d, expHalf1(w, n));
      chk("R8 first-half read keeps ready", wordReady, 1);
      readHalf(1'b1, d, di);
      chk("R6/R2 second half", d, expHalf2(w, n));
      chk("R8 second-half read clears", wordReady, 0);
    end
    shortWord = 1'b0;

    // R4 directed parity
    sendWord(32'h0000_0001, 32, 10, 1'b0, -1);
    readHalf(1'b1, d, di);
    readHalf(1'b0, d, di);
    chk("R4 odd count gives 0", d[8], 0);
    sendWord(32'h0000_0003, 32, 10, 1'b0, -1);
    readHalf(1'b0, d, di);
    chk("R4 even count gives 1", d[8], 1);
    readHalf(1'b1, d, di);

    // R1 slow rate
    slowRate = 1'b1;
    w = $urandom();
    sendWord(w, 32, 80, 1'b0, -1);
    chk("R1 slow rate ready", wordReady, 1);
    readHalf(1'b0, d, di);
    chk("R1 slow rate first half", d, expHalf1(w, 32));
    readHalf(1'b1, d, di);
    chk("R1 slow rate second half", d, expHalf2(w, 32));
    slowRate = 1'b0;
    repeat (200) @(negedge clk);

    // R5 filter: bits 9,10 = 1,0
    w = ($urandom() & 32'hFFFF_FCFF) | 32'h0000_0100;
    sdEnable = 1'b1; sdMatchX = 1'b0; sdMatchY = 1'b0;
    sendWord(w, 32, 10, 1'b0, -1);
    chk("R5 mismatch rejected", wordReady, 0);
    sdMatchX = 1'b1;
    sendWord(w, 32, 10, 1'b0, -1);
    chk("R5 match accepted", wordReady, 1);
    readHalf(1'b0, d, di);
    chk("R5 match data", d, expHalf1(w, 32));
    readHalf(1'b1, d, di);
    sdEnable = 1'b0; sdMatchX = 1'b0; sdMatchY = 1'b1;
    sendWord(w, 32, 10, 1'b0, -1);
    chk("R5 filter off ignores match bits", wordReady, 1);

    // R7 bus gating
    @(negedge clk); hostEn = 1'b0; hostSel = 1'b0; #1;
    chk("R7 disabled bus is zero", hostData, 16'h0);
    readHalf(1'b1, d, di);

    // R9 overwrite
    w = $urandom();
    sendWord($urandom(), 32, 10, 1'b0, -1);
    sendWord(w, 32, 10, 1'b0, -1);
    chk("R9 ready kept", wordReady, 1);
    readHalf(1'b0, d, di);
    chk("R9 newest first half", d, expHalf1(w, 32));
    readHalf(1'b1, d, di);
    chk("R9 newest second half", d, expHalf2(w, 32));

    // R10 partial and overlong words discarded
    sendWord($urandom(), 20, 10, 1'b0, -1);
    chk("R10 partial no ready", wordReady, 0);
    readHalf(1'b1, d, di);
    chk("R10 partial keeps stored word", d, expHalf2(w, 32));
    shortWord = 1'b1;
    sendWord($urandom(), 32, 10, 1'b0, -1);
    chk("R10/R2 overlong no ready", wordReady, 0);
    shortWord = 1'b0;

    // R3 glitch rejection
    w = $urandom();
    sendWord(w, 32, 10, 1'b0, 5);
    chk("R3 glitch word ready", wordReady, 1);
    readHalf(1'b0, d, di);
    chk("R3 glitch ignored first half", d, expHalf1(w, 32));
    readHalf(1'b1, d, di);
    chk("R3 glitch ignored second half", d, expHalf2(w, 32));

    // R11 loopback, line held at a steady HI
    loopEn = 1'b1;
    @(negedge clk); lineA = 1'b1; lineB = 1'b0;
    w = $urandom();
    sendWord(w, 32, 10, 1'b1, -1);
    chk("R11 loop ready", wordReady, 1);
    chk("R11 inverted loop ready", readyInv, 1);
    readHalf(1'b0, d, di);
    chk("R11 loop first half", d, expHalf1(w, 32));
    chk("R11 inverted first half", di, expHalf1(~w, 32));
    readHalf(1'b1, d, di);
    chk("R11 inverted second half", di, expHalf2(~w, 32));
    loopEn = 1'b0;
    @(negedge clk); lineA = 1'b0; lineB = 1'b0;
    repeat (40) @(negedge clk);

    // R12 reset clears stored word
    sendWord($urandom(), 32, 10, 1'b0, -1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R12 reset clears ready", wordReady, 0);
    @(negedge clk); hostEn = 1'b1; #1;
    chk("R12 reset clears data", hostData, 16'h0);
    @(negedge clk); hostEn = 1'b0;

    finishRun();
  end
endmodule